// File: doc/BRIEF.md
# Register-File Paged Address Translator

This block maps 16-bit virtual word addresses from a processor onto 16-bit physical addresses. The upper byte of the virtual address picks one of 256 page descriptors held in flip-flops inside the block. The lower byte is carried through unchanged as the word offset. Each descriptor holds an 8-bit frame number, a 2-bit permission code, a dirty flag and four software-only bits. Every request states its access type, which is read, write or instruction fetch. The block compares that type with the descriptor's permission code. It returns either a physical address or a trap code, never both.

Requests come in on a valid/ready channel and are held in one register stage. The response is formed from that stage against the current table and offered on a second valid/ready channel. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the stage is empty or its response is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays presented and no new request is taken. Software loads a whole descriptor by page index through a plain write port. It can look at any descriptor through a plain read port.

Top module: `pgx_translator`

## Requirements
- R1: After reset, `rsp_valid` is 0, every descriptor reads back as all zeros, and a request to any page therefore traps as invalid.
- R2: When no trap is raised, `rsp_paddr` equals the descriptor's frame number in bits [15:8] and the request's unchanged offset in bits [7:0].
- R3: A descriptor whose permission code is 2'b00 (invalid) gives `rsp_trap` = 2'b01 and `rsp_paddr` = 0, for every access type.
- R4: The permission codes are 2'b01 read-only, 2'b10 read-write and 2'b11 fetch-only. The access types are 2'b00 read, 2'b01 write and 2'b10 fetch; 2'b11 is reserved and never permitted. A read is allowed on codes 01 and 10, a write only on 10, and a fetch only on 11. Any other pairing on a valid page gives `rsp_trap` = 2'b10 and `rsp_paddr` = 0. A permitted access gives `rsp_trap` = 2'b00.
- R5: A permitted write sets the dirty flag of its page at the clock edge where its response is taken. A trapped write and any read or fetch leave the flag unchanged.
- R6: A table write to a page in the same cycle as a dirty-flag update for that page wins: the loaded descriptor, including its dirty value, is what remains.
- R7: The software-only bits and the dirty flag have no effect on translation or trapping. Software-only bits read back exactly as loaded.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and the presented response stays unchanged. A request that arrives during the stall is taken on the edge where the stalled response is taken.
- R9: A request taken at a clock edge has its response presented (`rsp_valid` = 1) right after that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request stage can take a request |
| req_vaddr | input | 16 | Virtual word address |
| req_kind | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 16 | Physical address, zero when trapping |
| rsp_trap | output | 2 | 00 none, 01 invalid page, 10 protection violation |
| tw_en | input | 1 | Table write strobe |
| tw_page | input | 8 | Page index to load |
| tw_frame | input | 8 | Frame number to load |
| tw_perm | input | 2 | Permission code to load |
| tw_dirty | input | 1 | Dirty flag to load |
| tw_soft | input | 4 | Software-only bits to load |
| rd_page | input | 8 | Page index to inspect |
| rd_frame | output | 8 | Frame number of inspected page |
| rd_perm | output | 2 | Permission code of inspected page |
| rd_dirty | output | 1 | Dirty flag of inspected page |
| rd_soft | output | 4 | Software-only bits of inspected page |

## Verification
A corrupted descriptor shows up on the very next response for its page, as a wrong frame byte or a wrong trap code. It also shows up at once on the inspection port. A lost or spurious dirty update shows on the inspection port one edge after the response handshake. A stuck request stage shows as a missing or repeated `rsp_valid` in the cycle after acceptance. The bench loads every page with an arithmetic pattern and tries all access types on each one, so any page-specific fault shows within that sweep.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  // permission codes held in each descriptor
  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b10;
  localparam logic [1:0] PERM_XO   = 2'b11;
  // access types carried with a request
  localparam logic [1:0] KIND_RD   = 2'b00;
  localparam logic [1:0] KIND_WR   = 2'b01;
  localparam logic [1:0] KIND_FX   = 2'b10;
  // trap codes
  localparam logic [1:0] TRAP_NONE = 2'b00;
  localparam logic [1:0] TRAP_INV  = 2'b01;
  localparam logic [1:0] TRAP_PROT = 2'b10;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int PAGE_W  = 8,
  parameter int FRAME_W = 8,
  parameter int SOFT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [1:0]         wr_perm,
  input  logic               wr_dirty,
  input  logic [SOFT_W-1:0]  wr_soft,
  input  logic               ds_en,
  input  logic [PAGE_W-1:0]  ds_page,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [1:0]         lk_perm,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [1:0]         rd_perm,
  output logic               rd_dirty,
  output logic [SOFT_W-1:0]  rd_soft
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [FRAME_W-1:0] frame_q [DEPTH];
  logic [1:0]         perm_q  [DEPTH];
  logic               dirty_q [DEPTH];
  logic [SOFT_W-1:0]  soft_q  [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        frame_q[i] <= '0;
        perm_q[i]  <= '0;
        dirty_q[i] <= 1'b0;
        soft_q[i]  <= '0;
      end else if (wr_en && wr_page == PAGE_W'(i)) begin
        frame_q[i] <= wr_frame;
        perm_q[i]  <= wr_perm;
        dirty_q[i] <= wr_dirty;
        soft_q[i]  <= wr_soft;
      end else if (ds_en && ds_page == PAGE_W'(i)) begin
        dirty_q[i] <= 1'b1;
      end
    end
  end

  assign lk_frame = frame_q[lk_page];
  assign lk_perm  = perm_q[lk_page];
  assign rd_frame = frame_q[rd_page];
  assign rd_perm  = perm_q[rd_page];
  assign rd_dirty = dirty_q[rd_page];
  assign rd_soft  = soft_q[rd_page];

  // R6
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (dirty_q[$past(wr_page)] == $past(wr_dirty)) &&
              (perm_q[$past(wr_page)] == $past(wr_perm)));
  // R5
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_en && !(wr_en && wr_page == ds_page)) |=> dirty_q[$past(ds_page)]);
endmodule

// File: rtl/pgx_perm.sv
module pgx_perm
  import pgx_pkg::*;
(
  input  logic [1:0] perm,
  input  logic [1:0] kind,
  output logic [1:0] trap
);
  logic allowed;

  always_comb begin
    unique case (kind)
      KIND_RD: allowed = (perm == PERM_RO) || (perm == PERM_RW);
      KIND_WR: allowed = (perm == PERM_RW);
      KIND_FX: allowed = (perm == PERM_XO);
      default: allowed = 1'b0;
    endcase
    if (perm == PERM_NONE) trap = TRAP_INV;
    else if (allowed)      trap = TRAP_NONE;
    else                   trap = TRAP_PROT;
  end
endmodule

// File: rtl/pgx_req_stage.sv
module pgx_req_stage #(
  parameter int VA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VA_W-1:0] in_vaddr,
  input  logic [1:0]      in_kind,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VA_W-1:0] out_vaddr,
  output logic [1:0]      out_kind
);
  logic            v_q;
  logic [VA_W-1:0] a_q;
  logic [1:0]      k_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
      k_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= in_vaddr;
        k_q <= in_kind;
      end
    end
  end

  assign out_valid = v_q;
  assign out_vaddr = a_q;
  assign out_kind  = k_q;

  // R9
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_vaddr) && $stable(out_kind));
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int SOFT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [PAGE_W+OFF_W-1:0]  req_vaddr,
  input  logic [1:0]               req_kind,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]               rsp_trap,
  input  logic                     tw_en,
  input  logic [PAGE_W-1:0]        tw_page,
  input  logic [FRAME_W-1:0]       tw_frame,
  input  logic [1:0]               tw_perm,
  input  logic                     tw_dirty,
  input  logic [SOFT_W-1:0]        tw_soft,
  input  logic [PAGE_W-1:0]        rd_page,
  output logic [FRAME_W-1:0]       rd_frame,
  output logic [1:0]               rd_perm,
  output logic                     rd_dirty,
  output logic [SOFT_W-1:0]        rd_soft
);
  localparam int VA_W = PAGE_W + OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;

  logic [VA_W-1:0]    q_vaddr;
  logic [1:0]         q_kind;
  logic [FRAME_W-1:0] lk_frame;
  logic [1:0]         lk_perm;
  logic [1:0]         trap;
  logic               ds_en;

  pgx_req_stage #(.VA_W(VA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_vaddr(req_vaddr), .in_kind(req_kind),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_vaddr(q_vaddr), .out_kind(q_kind)
  );

  pgx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .SOFT_W(SOFT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tw_en), .wr_page(tw_page), .wr_frame(tw_frame),
    .wr_perm(tw_perm), .wr_dirty(tw_dirty), .wr_soft(tw_soft),
    .ds_en(ds_en), .ds_page(q_vaddr[VA_W-1:OFF_W]),
    .lk_page(q_vaddr[VA_W-1:OFF_W]), .lk_frame(lk_frame), .lk_perm(lk_perm),
    .rd_page(rd_page), .rd_frame(rd_frame), .rd_perm(rd_perm),
    .rd_dirty(rd_dirty), .rd_soft(rd_soft)
  );

  pgx_perm u_perm (.perm(lk_perm), .kind(q_kind), .trap(trap));

  assign rsp_trap  = trap;
  assign rsp_paddr = (trap == TRAP_NONE) ? {lk_frame, q_vaddr[OFF_W-1:0]} : '0;
  assign ds_en     = rsp_valid && rsp_ready && (q_kind == KIND_WR) && (trap == TRAP_NONE);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap == TRAP_NONE) |-> rsp_paddr[OFF_W-1:0] == q_vaddr[OFF_W-1:0]);
  // R3
  inv_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && lk_perm == PERM_NONE) |-> (rsp_trap == TRAP_INV) && (rsp_paddr == '0));
  // R4
  prot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap == TRAP_PROT) |-> rsp_paddr == PA_W'(0));
endmodule

// File: tb/sim_pgx_translator.sv
module sim_pgx_translator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_trap;
  logic        tw_en = 1'b0;
  logic [7:0]  tw_page = '0;
  logic [7:0]  tw_frame = '0;
  logic [1:0]  tw_perm = '0;
  logic        tw_dirty = 1'b0;
  logic [3:0]  tw_soft = '0;
  logic [7:0]  rd_page = '0;
  logic [7:0]  rd_frame;
  logic [1:0]  rd_perm;
  logic        rd_dirty;
  logic [3:0]  rd_soft;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pgx_translator u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_trap(input logic [1:0] perm, input logic [1:0] kind);
    if (perm == 2'b00) return 2'b01;
    if (kind == 2'b00 && (perm == 2'b01 || perm == 2'b10)) return 2'b00;
    if (kind == 2'b01 && perm == 2'b10) return 2'b00;
    if (kind == 2'b10 && perm == 2'b11) return 2'b00;
    return 2'b10;
  endfunction

  task automatic load(input logic [7:0] pg, input logic [7:0] fr, input logic [1:0] pm,
                      input logic dt, input logic [3:0] sf);
    @(negedge clk);
    tw_en = 1'b1; tw_page = pg; tw_frame = fr; tw_perm = pm; tw_dirty = dt; tw_soft = sf;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  // one request, response checked right after the accepting edge
  task automatic xact(input logic [15:0] va, input logic [1:0] kind,
                      input logic [1:0] etrap, input logic [15:0] epa, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R9 valid", 32'(rsp_valid), 1);
    chk(rsp_trap == etrap, tag, 32'(rsp_trap), 32'(etrap));
    chk(rsp_paddr == epa, tag, 32'(rsp_paddr), 32'(epa));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    for (int p = 0; p < 256; p += 51) begin
      rd_page = 8'(p);
      #1;
      chk({rd_frame, rd_perm, rd_dirty, rd_soft} == '0, "R1 entry",
          32'({rd_frame, rd_perm, rd_dirty, rd_soft}), 0);
    end
    xact(16'h0512, 2'b00, 2'b01, 16'h0000, "R1 trap after reset");
    @(negedge clk);

    // load every page: frame=p^A5, perm=p[1:0], soft=p[7:4], dirty=0
    for (int p = 0; p < 256; p++)
      load(8'(p), 8'(p) ^ 8'hA5, 2'(p), 1'b0, 4'(p >> 4));

    // sweep all pages and access types (R2 R3 R4 R7)
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0]  off;
        logic [1:0]  et;
        logic [15:0] ep;
        off = 8'(p * 3 + k);
        et  = exp_trap(2'(p), 2'(k));
        ep  = (et == 2'b00) ? {8'(p) ^ 8'hA5, off} : 16'h0000;
        xact({8'(p), off}, 2'(k), et, ep, "R2/R3/R4 R7 sweep");
      end
    end
    @(negedge clk);
    // reserved kind is never permitted (R4)
    xact(16'h0610, 2'b11, 2'b10, 16'h0000, "R4 reserved kind");
    @(negedge clk);

    // dirty and soft readback (R5 R7)
    for (int p = 0; p < 256; p++) begin
      rd_page = 8'(p);
      #1;
      chk(rd_dirty == (2'(p) == 2'b10), "R5 dirty", 32'(rd_dirty), 32'(2'(p) == 2'b10));
      chk(rd_soft == 4'(p >> 4), "R7 soft", 32'(rd_soft), 32'(p >> 4));
    end

    // R7: dirty set and soft bits changed; translation unchanged
    load(8'h06, 8'h3C, 2'b10, 1'b1, 4'hF);
    xact(16'h0677, 2'b01, 2'b00, 16'h3C77, "R7 dirty/soft no effect");
    @(negedge clk);

    // R6: table write collides with dirty update on the same page
    load(8'h0A, 8'h11, 2'b10, 1'b0, 4'h0);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'h0A01; req_kind = 2'b01; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    tw_en = 1'b1; tw_page = 8'h0A; tw_frame = 8'h22; tw_perm = 2'b10; tw_dirty = 1'b0; tw_soft = 4'h3;
    @(negedge clk);
    tw_en = 1'b0;
    rd_page = 8'h0A;
    #1;
    chk(rd_dirty == 1'b0, "R6 write wins", 32'(rd_dirty), 0);
    chk(rd_frame == 8'h22, "R6 frame", 32'(rd_frame), 32'h22);

    // R5: trapped write leaves dirty clear
    load(8'h0B, 8'h44, 2'b01, 1'b0, 4'h0);
    xact(16'h0B05, 2'b01, 2'b10, 16'h0000, "R5 trapped write");
    @(negedge clk);
    rd_page = 8'h0B;
    #1;
    chk(rd_dirty == 1'b0, "R5 no dirty on trap", 32'(rd_dirty), 0);

    // R8 back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'h0D40; req_kind = 2'b00; rsp_ready = 1'b0;
    @(negedge clk);
    req_vaddr = 16'h0E41;
    for (int c = 0; c < 3; c++) begin
      chk(rsp_valid && !req_ready, "R8 stall", 32'({rsp_valid, req_ready}), 32'h2);
      chk(rsp_paddr == {8'h0D ^ 8'hA5, 8'h40}, "R8 hold", 32'(rsp_paddr), 32'({8'h0D ^ 8'hA5, 8'h40}));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_paddr == {8'h0E ^ 8'hA5, 8'h41}, "R8 next taken",
        32'(rsp_paddr), 32'({8'h0E ^ 8'hA5, 8'h41}));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 drained", 32'(rsp_valid), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule